// File: doc/BRIEF.md
# Three-Wire Bluetooth/WLAN Packet Arbiter

This block decides, packet by packet, whether a co-located WLAN MAC or a Bluetooth radio may use the air when both want it. The Bluetooth side talks over two wires: a request line, and a state line that carries two bits one after the other. The first bit, sampled one microsecond tick after the request rises, is the packet priority. The second, sampled on the next tick, is the direction. The arbiter answers on one output. When that output is low, Bluetooth may transmit. When it is high, Bluetooth must hold off. A second output grants the WLAN MAC its current request.

WLAN priority comes from the 6-bit packet type of the pending request. It indexes a 64-bit mask, with one mask for transmit and one for receive. A set bit means high priority. The arbitration outcome is looked up in one of two 32-bit decision tables, selected by an in-band/out-of-band mode bit. A single-antenna mode bit makes access exclusive and lets a high-priority WLAN request cut into an ongoing Bluetooth transaction. Time comes from a one-cycle microsecond tick. A small configuration write port loads the masks, the tables and the mode.

Top module: `coex3w_arbiter`

## Requirements
- R1: After reset, `wl_grant` and `wlan_active` are 0. Both masks hold only bit 29, the WLAN ACK type. The decision tables hold the defaults of R6. The mode register is 0.
- R2: The priority of a request is the mask bit indexed by its packet type. When `wl_tx_req` is 1, the transmit type and transmit mask are used, even if a receive request is also present. Otherwise the receive type and receive mask are used. Configuration addresses 0 and 1 write bits 31:0 and 63:32 of the transmit mask. Addresses 2 and 3 do the same for the receive mask.
- R3: While no Bluetooth request is being handled, both `wl_grant` and `wlan_active` follow the WLAN request (either direction), one cycle late.
- R4: The first `us_tick` after `bt_pri_in` rises samples `bt_state_in` as the Bluetooth priority (1 = high). The second tick samples it as the direction (1 = transmit). Later changes of `bt_state_in` have no effect until the next rise.
- R5: The table key is {wl_hi, wl_tx, bt_hi, bt_tx}, with wl_hi as its MSB. Bits [2k+1] and [2k] of the selected table give wlan_ok and bt_ok. Address 4 writes the in-band table and address 5 the out-of-band table. Address 6 writes the mode: bit 0 selects out-of-band and bit 1 selects single antenna.
- R6: Default tables: a high-priority WLAN request wins over any Bluetooth packet. A high-priority Bluetooth packet wins over a low-priority WLAN request. Two low-priority requests go to WLAN. The out-of-band table also allows both sides when both transmit.
- R7: While the arbitration window is open (WIN_US ticks counted from the rise), a present WLAN request gets `wl_grant` = wlan_ok and `wlan_active` = not bt_ok. This can stop a WLAN packet that is already granted. With no WLAN request, both outputs are 0.
- R8: After the window closes and while Bluetooth still requests, the outcome is held. A WLAN request arriving then is not granted, except as in R9.
- R9: In single-antenna mode, a high-priority WLAN request after the window has closed sets both `wl_grant` and `wlan_active` to 1 one cycle later. This stops Bluetooth.
- R10: In single-antenna mode, an outcome that allows both sides is reduced to one side: WLAN if the WLAN request is high priority, otherwise Bluetooth.
- R11: When `bt_pri_in` falls, the window closes at once, and the following cycle's outputs follow R3.
- R12: Between the rise of `bt_pri_in` and the direction sample, both outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| bt_pri_in | input | 1 | Bluetooth request/priority line |
| bt_state_in | input | 1 | Bluetooth serial state line (priority, then direction) |
| wl_tx_req | input | 1 | WLAN transmit request |
| wl_tx_type | input | TYPE_W | Packet type of the transmit request |
| wl_rx_req | input | 1 | WLAN receive request |
| wl_rx_type | input | TYPE_W | Packet type of the receive request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| wl_grant | output | 1 | WLAN may proceed with its request |
| wlan_active | output | 1 | 1 forbids Bluetooth transmission, 0 allows it |

## Verification
A wrong captured Bluetooth priority or direction shows as the wrong table outcome on `wl_grant` and `wlan_active`. It appears in the cycle after the second sampling tick and stays there for the whole window. Scenarios are therefore chosen so that the two possible captured values give different outputs. A wrong mask bit or table entry shows the same way, as soon as a WLAN request of that type meets a classified Bluetooth request. A window counter that runs short or long shows only after the window: a late low-priority WLAN request is then granted, or a single-antenna preempt appears where none is due. The checks sample a few cycles after the window boundary.

// File: rtl/coex3w_pkg.sv
package coex3w_pkg;

    typedef enum logic [1:0] {
        BT_IDLE    = 2'd0,
        BT_GET_PRI = 2'd1,
        BT_GET_DIR = 2'd2,
        BT_ARB     = 2'd3
    } bt_phase_e;

    typedef struct packed {
        logic wl_hi;
        logic wl_tx;
        logic bt_hi;
        logic bt_tx;
    } arb_key_t;

    typedef struct packed {
        logic wl_ok;
        logic bt_ok;
    } verdict_t;

    localparam int KEY_W = $bits(arb_key_t);
    localparam int VER_W = $bits(verdict_t);
    localparam int TAB_W = VER_W * (2 ** KEY_W);

    // Reset contents of a decision table.
    function automatic logic [TAB_W-1:0] default_table(input logic oob);
        logic [TAB_W-1:0] t;
        t = '0;
        for (int i = 0; i < 2 ** KEY_W; i++) begin
            arb_key_t k;
            verdict_t v;
            k = arb_key_t'(KEY_W'(i));
            if (k.wl_hi || !k.bt_hi) v = '{wl_ok: 1'b1, bt_ok: 1'b0};
            else                      v = '{wl_ok: 1'b0, bt_ok: 1'b1};
            if (oob && k.wl_tx && k.bt_tx) v = '{wl_ok: 1'b1, bt_ok: 1'b1};
            t[i*VER_W +: VER_W] = v;
        end
        return t;
    endfunction

    // One shared antenna: never let both sides through.
    function automatic verdict_t single_reduce(input verdict_t v, input logic wl_hi);
        verdict_t r;
        r = v;
        if (v.wl_ok && v.bt_ok) begin
            r.wl_ok = wl_hi;
            r.bt_ok = !wl_hi;
        end
        return r;
    endfunction

endpackage

// File: rtl/coex3w_classifier.sv
module coex3w_classifier
    import coex3w_pkg::*;
#(
    parameter int TYPE_W   = 6,
    parameter int ACK_TYPE = 29,
    parameter int CFG_AW   = 3,
    parameter int TX_BASE  = 0,
    parameter int RX_BASE  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              tx_req,
    input  logic [TYPE_W-1:0] tx_type,
    input  logic              rx_req,
    input  logic [TYPE_W-1:0] rx_type,
    output logic              wl_any,
    output logic              wl_tx,
    output logic              wl_hi
);
    localparam int MASK_W = 2 ** TYPE_W;
    localparam int WORDS  = MASK_W / 32;
    localparam int NPATH  = 2;

    logic [NPATH-1:0] path_hi;

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        localparam int BASE = (p == 0) ? TX_BASE : RX_BASE;
        logic [MASK_W-1:0] mask_q;
        logic [TYPE_W-1:0] sel_type;

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q <= MASK_W'(1) << ACK_TYPE;
            end else if (cfg_we) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (cfg_addr == CFG_AW'(BASE + w))
                        mask_q[w*32 +: 32] <= cfg_wdata;
                end
            end
        end

        assign sel_type   = (p == 0) ? tx_type : rx_type;
        assign path_hi[p] = mask_q[sel_type];
    end

    assign wl_any = tx_req | rx_req;
    assign wl_tx  = tx_req;
    assign wl_hi  = tx_req ? path_hi[0] : (rx_req & path_hi[1]);

endmodule

// File: rtl/coex3w_bt_decoder.sv
module coex3w_bt_decoder
    import coex3w_pkg::*;
#(
    parameter int WIN_US = 75
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      us_tick,
    input  logic      bt_pri_in,
    input  logic      bt_state_in,
    output bt_phase_e phase,
    output logic      bt_hi,
    output logic      bt_tx,
    output logic      win_open
);
    localparam int CNT_W = $clog2(WIN_US + 1);
    localparam logic [CNT_W-1:0] WIN_END = CNT_W'(WIN_US);

    logic             pri_prev;
    logic [CNT_W-1:0] tick_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= BT_IDLE;
            pri_prev <= 1'b0;
            tick_cnt <= '0;
            bt_hi    <= 1'b0;
            bt_tx    <= 1'b0;
        end else begin
            pri_prev <= bt_pri_in;
            if (!bt_pri_in) begin
                phase    <= BT_IDLE;
                tick_cnt <= '0;
            end else begin
                unique case (phase)
                    BT_IDLE: begin
                        if (!pri_prev) begin
                            phase    <= BT_GET_PRI;
                            tick_cnt <= '0;
                        end
                    end
                    BT_GET_PRI: begin
                        if (us_tick) begin
                            bt_hi    <= bt_state_in;
                            tick_cnt <= CNT_W'(1);
                            phase    <= BT_GET_DIR;
                        end
                    end
                    BT_GET_DIR: begin
                        if (us_tick) begin
                            bt_tx    <= bt_state_in;
                            tick_cnt <= CNT_W'(2);
                            phase    <= BT_ARB;
                        end
                    end
                    BT_ARB: begin
                        if (us_tick && tick_cnt < WIN_END)
                            tick_cnt <= tick_cnt + 1'b1;
                    end
                    default: phase <= BT_IDLE;
                endcase
            end
        end
    end

    assign win_open = (phase == BT_ARB) && (tick_cnt < WIN_END);

endmodule

// File: rtl/coex3w_decision.sv
module coex3w_decision
    import coex3w_pkg::*;
#(
    parameter int CFG_AW    = 3,
    parameter int TAB_IB_A  = 4,
    parameter int TAB_OOB_A = 5,
    parameter int MODE_A    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  bt_phase_e         phase,
    input  logic              win_open,
    input  logic              bt_hi,
    input  logic              bt_tx,
    input  logic              wl_any,
    input  logic              wl_tx,
    input  logic              wl_hi,
    output logic              single_ant,
    output logic              wl_grant,
    output logic              wlan_active
);
    logic [TAB_W-1:0] tab_ib_q, tab_oob_q, tab_sel;
    logic             oob_q, single_q;
    arb_key_t         key;
    verdict_t         raw_v, fin_v;
    logic             grant_n, active_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            tab_ib_q  <= default_table(1'b0);
            tab_oob_q <= default_table(1'b1);
            oob_q     <= 1'b0;
            single_q  <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(TAB_IB_A))  tab_ib_q  <= cfg_wdata[TAB_W-1:0];
            if (cfg_addr == CFG_AW'(TAB_OOB_A)) tab_oob_q <= cfg_wdata[TAB_W-1:0];
            if (cfg_addr == CFG_AW'(MODE_A)) begin
                oob_q    <= cfg_wdata[0];
                single_q <= cfg_wdata[1];
            end
        end
    end

    always_comb begin
        key     = '{wl_hi: wl_hi, wl_tx: wl_tx, bt_hi: bt_hi, bt_tx: bt_tx};
        tab_sel = oob_q ? tab_oob_q : tab_ib_q;
        raw_v   = verdict_t'(tab_sel[key*VER_W +: VER_W]);
        fin_v   = single_q ? single_reduce(raw_v, wl_hi) : raw_v;
    end

    always_comb begin
        grant_n  = wl_grant;
        active_n = wlan_active;
        unique case (phase)
            BT_IDLE: begin
                grant_n  = wl_any;
                active_n = wl_any;
            end
            BT_GET_PRI, BT_GET_DIR: begin
                grant_n  = wl_grant;
                active_n = wlan_active;
            end
            BT_ARB: begin
                if (!wl_any) begin
                    grant_n  = 1'b0;
                    active_n = 1'b0;
                end else if (win_open) begin
                    grant_n  = fin_v.wl_ok;
                    active_n = !fin_v.bt_ok;
                end else if (single_q && wl_hi) begin
                    grant_n  = 1'b1;
                    active_n = 1'b1;
                end
            end
            default: begin
                grant_n  = 1'b0;
                active_n = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wl_grant    <= 1'b0;
            wlan_active <= 1'b0;
        end else begin
            wl_grant    <= grant_n;
            wlan_active <= active_n;
        end
    end

    assign single_ant = single_q;

endmodule

// File: rtl/coex3w_arbiter.sv
module coex3w_arbiter
    import coex3w_pkg::*;
#(
    parameter int TYPE_W   = 6,
    parameter int ACK_TYPE = 29,
    parameter int WIN_US   = 75,
    parameter int CFG_AW   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              bt_pri_in,
    input  logic              bt_state_in,
    input  logic              wl_tx_req,
    input  logic [TYPE_W-1:0] wl_tx_type,
    input  logic              wl_rx_req,
    input  logic [TYPE_W-1:0] wl_rx_type,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              wl_grant,
    output logic              wlan_active
);
    localparam int MASK_WORDS = (2 ** TYPE_W) / 32;
    localparam int TX_BASE    = 0;
    localparam int RX_BASE    = MASK_WORDS;
    localparam int TAB_IB_A   = 2 * MASK_WORDS;
    localparam int TAB_OOB_A  = TAB_IB_A + 1;
    localparam int MODE_A     = TAB_IB_A + 2;

    logic      wl_any, wl_tx, wl_hi;
    bt_phase_e bt_phase;
    logic      bt_hi, bt_tx, win_open, single_ant;

    coex3w_classifier #(
        .TYPE_W(TYPE_W), .ACK_TYPE(ACK_TYPE), .CFG_AW(CFG_AW),
        .TX_BASE(TX_BASE), .RX_BASE(RX_BASE)
    ) u_class (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tx_req(wl_tx_req), .tx_type(wl_tx_type),
        .rx_req(wl_rx_req), .rx_type(wl_rx_type),
        .wl_any(wl_any), .wl_tx(wl_tx), .wl_hi(wl_hi)
    );

    coex3w_bt_decoder #(.WIN_US(WIN_US)) u_btdec (
        .clk(clk), .rst(rst), .us_tick(us_tick),
        .bt_pri_in(bt_pri_in), .bt_state_in(bt_state_in),
        .phase(bt_phase), .bt_hi(bt_hi), .bt_tx(bt_tx), .win_open(win_open)
    );

    coex3w_decision #(
        .CFG_AW(CFG_AW), .TAB_IB_A(TAB_IB_A), .TAB_OOB_A(TAB_OOB_A), .MODE_A(MODE_A)
    ) u_dec (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .phase(bt_phase), .win_open(win_open), .bt_hi(bt_hi), .bt_tx(bt_tx),
        .wl_any(wl_any), .wl_tx(wl_tx), .wl_hi(wl_hi),
        .single_ant(single_ant), .wl_grant(wl_grant), .wlan_active(wlan_active)
    );

endmodule

// File: rtl/coex3w_checker.sv
module coex3w_checker
    import coex3w_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      bt_pri_in,
    input bt_phase_e phase,
    input logic      win_open,
    input logic      bt_hi,
    input logic      bt_tx,
    input logic      wl_any,
    input logic      wl_hi,
    input logic      single_ant,
    input logic      wl_grant,
    input logic      wlan_active
);
    a_r3_idle_follows: assert property (@(posedge clk) disable iff (rst)
        (phase == BT_IDLE) |=> (wl_grant == $past(wl_any)) && (wlan_active == $past(wl_any)));

    a_r11_drop_to_idle: assert property (@(posedge clk) disable iff (rst)
        !bt_pri_in |=> (phase == BT_IDLE));

    a_r7_window_needs_request: assert property (@(posedge clk) disable iff (rst)
        !bt_pri_in |=> !win_open);

    a_r12_decode_holds: assert property (@(posedge clk) disable iff (rst)
        (phase == BT_GET_PRI || phase == BT_GET_DIR) |=> $stable(wl_grant) && $stable(wlan_active));

    a_r4_class_stable: assert property (@(posedge clk) disable iff (rst)
        (phase == BT_ARB && $past(phase) == BT_ARB) |-> $stable(bt_hi) && $stable(bt_tx));

    a_r9_single_preempt: assert property (@(posedge clk) disable iff (rst)
        (phase == BT_ARB && !win_open && single_ant && wl_any && wl_hi) |=> wl_grant && wlan_active);

    a_r10_single_exclusive: assert property (@(posedge clk) disable iff (rst)
        (phase == BT_ARB && win_open && single_ant) |=> !(wl_grant && !wlan_active));

endmodule

bind coex3w_arbiter coex3w_checker u_chk (
    .clk(clk), .rst(rst), .bt_pri_in(bt_pri_in), .phase(bt_phase),
    .win_open(win_open), .bt_hi(bt_hi), .bt_tx(bt_tx), .wl_any(wl_any),
    .wl_hi(wl_hi), .single_ant(single_ant), .wl_grant(wl_grant),
    .wlan_active(wlan_active)
);

// File: tb/coex3w_arbiter_bench.sv
module coex3w_arbiter_bench;
    localparam int TYPE_W = 6;
    localparam int ACK_T  = 29;
    localparam int WIN    = 75;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              us_tick = 1'b0;
    logic              bt_pri_in = 1'b0;
    logic              bt_state_in = 1'b0;
    logic              wl_tx_req = 1'b0;
    logic [TYPE_W-1:0] wl_tx_type = '0;
    logic              wl_rx_req = 1'b0;
    logic [TYPE_W-1:0] wl_rx_type = '0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              wl_grant, wlan_active;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    coex3w_arbiter u_coex3w_arbiter (
        .clk(clk), .rst(rst), .us_tick(us_tick),
        .bt_pri_in(bt_pri_in), .bt_state_in(bt_state_in),
        .wl_tx_req(wl_tx_req), .wl_tx_type(wl_tx_type),
        .wl_rx_req(wl_rx_req), .wl_rx_type(wl_rx_type),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .wl_grant(wl_grant), .wlan_active(wlan_active)
    );

    // Expected default table, built from the R6 rules.
    function automatic logic [31:0] rule_table(input bit oob);
        logic [31:0] t = '0;
        for (int i = 0; i < 16; i++) begin
            bit whi = i[3], wtx = i[2], bhi = i[1], btx = i[0];
            logic [1:0] r = (whi || !bhi) ? 2'b10 : 2'b01;
            if (oob && wtx && btx) r = 2'b11;
            t[2*i +: 2] = r;
        end
        return t;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic eg, input logic ea, input string req);
        checks++;
        if (wl_grant !== eg || wlan_active !== ea) begin
            fails++;
            $display("FAIL %s: grant=%0b active=%0b expected grant=%0b active=%0b",
                     req, wl_grant, wlan_active, eg, ea);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic tick_us(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            cyc(1);
            us_tick = 1'b0;
            cyc(3);
        end
    endtask

    task automatic bt_begin(input logic hi, input logic tx);
        bt_pri_in = 1'b1; bt_state_in = hi;
        cyc(1);
        tick_us(1);
        bt_state_in = tx;
        tick_us(1);
        cyc(1);
    endtask

    task automatic wl_set(input logic txr, input int txt, input logic rxr, input int rxt);
        wl_tx_req = txr; wl_tx_type = TYPE_W'(txt);
        wl_rx_req = rxr; wl_rx_type = TYPE_W'(rxt);
        cyc(2);
    endtask

    task automatic quiet();
        bt_pri_in = 1'b0; bt_state_in = 1'b0;
        wl_tx_req = 1'b0; wl_rx_req = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc(4);
        expect_out(1'b0, 1'b0, "R1 outputs during reset");
        rst = 1'b0;
        cyc(2);
        expect_out(1'b0, 1'b0, "R1 outputs after reset");
    endtask

    task automatic t_idle();
        wl_set(1'b1, 0, 1'b0, 0);
        expect_out(1'b1, 1'b1, "R3 idle tx request granted");
        wl_set(1'b0, 0, 1'b1, 5);
        expect_out(1'b1, 1'b1, "R3 idle rx request granted");
        quiet();
        expect_out(1'b0, 1'b0, "R3 idle no request");
    endtask

    task automatic t_defaults();
        bt_begin(1'b1, 1'b1);
        expect_out(1'b0, 1'b0, "R7 window no WLAN request");
        wl_set(1'b1, 0, 1'b0, 0);
        expect_out(1'b0, 1'b0, "R6 BT high beats WLAN low");
        wl_set(1'b1, ACK_T, 1'b0, 0);
        expect_out(1'b1, 1'b1, "R1 ACK type high by default");
        quiet();
        bt_begin(1'b0, 1'b0);
        wl_set(1'b0, 0, 1'b1, 0);
        expect_out(1'b1, 1'b1, "R6 low vs low goes to WLAN");
        quiet();
    endtask

    task automatic t_masks();
        wr(3'd1, 32'h0000_0100);   // tx type 40 high
        bt_begin(1'b1, 1'b1);
        wl_set(1'b1, 40, 1'b0, 0);
        expect_out(1'b1, 1'b1, "R2 programmed tx mask bit 40");
        wl_set(1'b0, 0, 1'b1, 40);
        expect_out(1'b0, 1'b0, "R2 rx mask unaffected by tx write");
        wl_set(1'b1, 40, 1'b1, 0);
        expect_out(1'b1, 1'b1, "R2 tx type takes precedence");
        quiet();
    endtask

    task automatic t_oob_and_tables();
        wr(3'd6, 32'd1);
        bt_begin(1'b1, 1'b1);
        wl_set(1'b1, 0, 1'b0, 0);
        expect_out(1'b1, 1'b0, "R6 out-of-band tx/tx both allowed");
        quiet();
        // R4: priority high, direction rx, state flips later
        bt_begin(1'b1, 1'b0);
        bt_state_in = 1'b1;
        wl_set(1'b1, 0, 1'b0, 0);
        expect_out(1'b0, 1'b0, "R4 direction sampled on second tick");
        tick_us(3);
        expect_out(1'b0, 1'b0, "R4 later state changes ignored");
        quiet();
        wr(3'd6, 32'd0);
        wr(3'd4, 32'hFFFF_FFFF);
        bt_begin(1'b1, 1'b1);
        wl_set(1'b0, 0, 1'b1, 0);
        expect_out(1'b1, 1'b0, "R5 custom in-band table");
        quiet();
        wr(3'd4, rule_table(1'b0));
        bt_begin(1'b1, 1'b1);
        wl_set(1'b0, 0, 1'b1, 0);
        expect_out(1'b0, 1'b0, "R5 restored in-band table");
        quiet();
    endtask

    task automatic t_decode_hold();
        wl_set(1'b1, 0, 1'b0, 0);
        bt_pri_in = 1'b1; bt_state_in = 1'b1;
        cyc(2);
        expect_out(1'b1, 1'b1, "R12 outputs held during decode");
        tick_us(1);
        expect_out(1'b1, 1'b1, "R12 held after priority sample");
        tick_us(1);
        cyc(1);
        expect_out(1'b0, 1'b0, "R7 granted WLAN stopped by BT");
        quiet();
    endtask

    task automatic t_window_close();
        bt_begin(1'b1, 1'b1);
        tick_us(WIN);
        wl_set(1'b1, 0, 1'b0, 0);
        expect_out(1'b0, 1'b0, "R8 late low WLAN request held off");
        wl_set(1'b1, ACK_T, 1'b0, 0);
        expect_out(1'b0, 1'b0, "R8 dual antenna no preempt");
        wr(3'd6, 32'd2);
        cyc(2);
        expect_out(1'b1, 1'b1, "R9 single antenna preempts BT");
        quiet();
    endtask

    task automatic t_single();
        wr(3'd6, 32'd3);
        bt_begin(1'b1, 1'b1);
        wl_set(1'b1, 0, 1'b0, 0);
        expect_out(1'b0, 1'b0, "R10 both-ok reduced to BT");
        wl_set(1'b1, ACK_T, 1'b0, 0);
        expect_out(1'b1, 1'b1, "R10 both-ok reduced to WLAN");
        quiet();
        wr(3'd6, 32'd0);
    endtask

    task automatic t_drop();
        bt_begin(1'b1, 1'b1);
        wl_set(1'b1, 0, 1'b0, 0);
        expect_out(1'b0, 1'b0, "R11 BT wins before drop");
        bt_pri_in = 1'b0;
        cyc(2);
        expect_out(1'b1, 1'b1, "R11 drop returns to idle grant");
        bt_begin(1'b1, 1'b1);
        expect_out(1'b0, 1'b0, "R11 new window after re-rise");
        quiet();
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_idle();
        t_defaults();
        t_masks();
        t_oob_and_tables();
        t_decode_hold();
        t_window_close();
        t_single();
        t_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule